// File: doc/BRIEF.md
# Reference Source Selector with Activity Detection

The block picks which of two timing references feeds a board: an internal disciplined source or an external one. The internal source reports its presence as a plain level. The external source has no such flag, so the block watches its reference input and calls it present only when that input changes level inside a fixed window of samples. A preference switch says which source to try first. When the preferred source is missing, the block falls back to the other one. When neither is present, it reports no source.

A new decision is made only when the debounced switch or the external presence result changes. The first decision after reset is always made, once the switch has been debounced. Each decision sets the pulse-per-second mux select and three status LEDs. It also sends a one-cycle reconfigure request with a 2-bit source code to a downstream configuration sequencer. Before the first decision, the block drives a fixed power-up state.

Top module: `ref_source_selector`

## Requirements
- R1: The external source counts as present only if the synchronised `ext_ref_i` changed level at least once during the last window of WIN_LEN clock samples. The result is updated at the end of each window and is absent after reset.
- R2: `int_present_i` is an active-high presence level for the internal source and is used without filtering.
- R3: `pref_ext_i` low prefers internal and high prefers external. A new switch level is accepted only after it has held for DEB_LEN consecutive cycles, so shorter glitches have no effect.
- R4: With internal preferred, the choice is internal if it is present, otherwise external if it is present, otherwise none.
- R5: With external preferred, the choice is external if it is present, otherwise internal if it is present, otherwise none.
- R6: Choosing internal sets `pps_sel_o`=1 and `led_o`=3'b101, where bit 2 is the top LED, bit 1 the middle LED and bit 0 the bottom LED. The code is 2'b01.
- R7: Choosing external sets `pps_sel_o`=0, `led_o`=3'b011 and code 2'b10.
- R8: Choosing none sets `led_o`=3'b000 and code 2'b00, and leaves `pps_sel_o` at its previous value.
- R9: A decision is made only when the debounced switch or the external presence result differs from the value stored at the last decision. A change of `int_present_i` alone causes no decision and no output change.
- R10: After reset, one decision is forced as soon as the switch has been debounced, whatever the inputs are.
- R11: From reset until the first decision, `pps_sel_o`=1, `led_o`=3'b110 and `reconf_o`=0.
- R12: Each decision raises `reconf_o` for one cycle, with `src_code_o` showing the chosen code. `src_code_o` holds that code until the next decision and is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the sampling clock for the reference input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pref_ext_i | input | 1 | Preference switch, asynchronous; 1 prefers external |
| int_present_i | input | 1 | Internal source present, active high |
| ext_ref_i | input | 1 | External reference signal to monitor, asynchronous |
| pps_sel_o | output | 1 | PPS mux select: 1 internal, 0 external |
| led_o | output | 3 | Status LEDs {top, middle, bottom} |
| reconf_o | output | 1 | One-cycle reconfigure request |
| src_code_o | output | 2 | Chosen source: 01 internal, 10 external, 00 none |

## Verification
The hardest situation to reach is a change of internal presence while the switch and the external result stay put. In that case the outputs must not follow, even though the fallback order would now pick something else. The bench changes one input at a time and waits long enough for several windows to close. It keeps a model of the stored switch and presence values, so it can tell whether a decision is due and check that no extra pulse appears. The other hard case is a switch glitch shorter than the debounce hold. A directed step covers it, and the run is mixed with seeded random single-input changes.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_INT  = 2'b01,
    SRC_EXT  = 2'b10
  } src_e;

  localparam int unsigned LED_W = 3;
  // {top, middle, bottom}
  localparam logic [LED_W-1:0] LED_BOOT = 3'b110;
  localparam logic [LED_W-1:0] LED_INT  = 3'b101;
  localparam logic [LED_W-1:0] LED_EXT  = 3'b011;
  localparam logic [LED_W-1:0] LED_OFF  = 3'b000;
endpackage

// File: rtl/refsel_sync2.sv
module refsel_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/refsel_debounce.sv
module refsel_debounce #(
  parameter int unsigned DEB_LEN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic valid_o
);
  localparam int unsigned CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_LEN - 1);

  logic          sync_s;
  logic [CW-1:0] cnt_q;
  logic          level_q, valid_q, prev_q;

  refsel_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_s)
  );

  // before valid: input must hold steady for a full count; after: must differ for a full count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
      valid_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      prev_q <= sync_s;
      if (valid_q && sync_s == level_q) begin
        cnt_q <= '0;
      end else if (!valid_q && sync_s != prev_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        level_q <= sync_s;
        valid_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign valid_o = valid_q;

  assert_accept_after_hold_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $past(cnt_q) == CNT_LAST
  );
endmodule

// File: rtl/refsel_activity.sv
module refsel_activity #(
  parameter int unsigned WIN_LEN = 65535
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic present_o
);
  localparam int unsigned CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_LEN - 1);

  logic          ref_s, prev_q, edge_s;
  logic [CW-1:0] cnt_q;
  logic          seen_q, present_q;

  refsel_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ref_i),
    .q_o   (ref_s)
  );

  assign edge_s = ref_s ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b0;
      cnt_q     <= '0;
      seen_q    <= 1'b0;
      present_q <= 1'b0;
    end else begin
      prev_q <= ref_s;
      if (cnt_q == WIN_LAST) begin
        cnt_q     <= '0;
        seen_q    <= 1'b0;
        present_q <= seen_q | edge_s;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        seen_q <= seen_q | edge_s;
      end
    end
  end

  assign present_o = present_q;

  assert_win_bound_R1: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WIN_LAST
  );

  assert_update_at_window_end_R1: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !$stable(present_q) |-> $past(cnt_q) == WIN_LAST
  );
endmodule

// File: rtl/refsel_decide.sv
module refsel_decide
  import refsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_valid_i,
  input  logic             pref_ext_i,
  input  logic             int_present_i,
  input  logic             ext_present_i,
  output logic             pps_sel_o,
  output logic [LED_W-1:0] led_o,
  output logic             reconf_o,
  output src_e             code_o
);
  logic             armed_q, sw_q, ext_q;
  logic             pps_q, reconf_q;
  logic [LED_W-1:0] led_q;
  src_e             code_q, pick;
  logic             trig;

  assign trig = sw_valid_i && (armed_q || pref_ext_i != sw_q || ext_present_i != ext_q);

  always_comb begin
    if (pref_ext_i) begin
      if (ext_present_i)      pick = SRC_EXT;
      else if (int_present_i) pick = SRC_INT;
      else                    pick = SRC_NONE;
    end else begin
      if (int_present_i)      pick = SRC_INT;
      else if (ext_present_i) pick = SRC_EXT;
      else                    pick = SRC_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b1;
      sw_q     <= 1'b0;
      ext_q    <= 1'b0;
      pps_q    <= 1'b1;
      led_q    <= LED_BOOT;
      reconf_q <= 1'b0;
      code_q   <= SRC_NONE;
    end else begin
      reconf_q <= trig;
      if (trig) begin
        armed_q <= 1'b0;
        sw_q    <= pref_ext_i;
        ext_q   <= ext_present_i;
        code_q  <= pick;
        unique case (pick)
          SRC_INT: begin pps_q <= 1'b1; led_q <= LED_INT; end
          SRC_EXT: begin pps_q <= 1'b0; led_q <= LED_EXT; end
          default: led_q <= LED_OFF;
        endcase
      end
    end
  end

  assign pps_sel_o = pps_q;
  assign led_o     = led_q;
  assign reconf_o  = reconf_q;
  assign code_o    = code_q;

  assert_no_change_no_decision_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (!sw_valid_i || (!armed_q && pref_ext_i == sw_q && ext_present_i == ext_q)) |=> !reconf_o
  );

  assert_int_drive_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (reconf_o && code_o == SRC_INT) |-> (pps_sel_o && led_o == LED_INT)
  );

  assert_ext_drive_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (reconf_o && code_o == SRC_EXT) |-> (!pps_sel_o && led_o == LED_EXT)
  );

  assert_none_keeps_pps_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (reconf_o && code_o == SRC_NONE) |-> (led_o == LED_OFF && $stable(pps_sel_o))
  );

  assert_power_up_state_R11: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (pps_sel_o && led_o == LED_BOOT && !reconf_o)
  );

  assert_code_legal_R12: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    code_o != 2'b11
  );
endmodule

// File: rtl/ref_source_selector.sv
module ref_source_selector
  import refsel_pkg::*;
#(
  parameter int unsigned WIN_LEN = 65535,
  parameter int unsigned DEB_LEN = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pref_ext_i,
  input  logic       int_present_i,
  input  logic       ext_ref_i,
  output logic       pps_sel_o,
  output logic [2:0] led_o,
  output logic       reconf_o,
  output logic [1:0] src_code_o
);
  logic sw_level, sw_valid, ext_present;
  src_e code;

  refsel_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (pref_ext_i),
    .level_o(sw_level),
    .valid_o(sw_valid)
  );

  refsel_activity #(.WIN_LEN(WIN_LEN)) u_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_i    (ext_ref_i),
    .present_o(ext_present)
  );

  refsel_decide u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_valid_i   (sw_valid),
    .pref_ext_i   (sw_level),
    .int_present_i(int_present_i),
    .ext_present_i(ext_present),
    .pps_sel_o    (pps_sel_o),
    .led_o        (led_o),
    .reconf_o     (reconf_o),
    .code_o       (code)
  );

  assign src_code_o = code;
endmodule

// File: tb/ref_source_selector_tb.sv
module ref_source_selector_tb;
  localparam int CLK_P  = 10;
  localparam int WIN    = 32;
  localparam int DEB    = 16;
  localparam int SETTLE = 4 * WIN + DEB + 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw = 1'b0, gps = 1'b1, ext_ref = 1'b0;
  logic       pps;
  logic [2:0] led;
  logic       reconf;
  logic [1:0] code;

  int  checks = 0, errors = 0, pulses = 0;
  bit  ext_run = 1'b0, done = 1'b0;
  logic [1:0] last_code = 2'b00;

  // model
  bit         m_sw = 1'b0, m_ext = 1'b0;
  int         m_pulses = 0;
  logic [1:0] m_code = 2'b00;
  logic [2:0] m_led = 3'b110;
  logic       m_pps = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  ref_source_selector #(.WIN_LEN(WIN), .DEB_LEN(DEB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pref_ext_i(sw), .int_present_i(gps),
    .ext_ref_i(ext_ref), .pps_sel_o(pps), .led_o(led), .reconf_o(reconf),
    .src_code_o(code)
  );

  // pulse monitor, samples away from the active edge (R12)
  initial forever begin
    @(negedge clk);
    if (reconf) begin
      pulses++;
      last_code = code;
    end
  end

  // external reference generator: toggles every 3 cycles while running
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph++;
        if (ph >= 3) begin ph = 0; ext_ref = ~ext_ref; end
      end
    end
  end

  function automatic logic [1:0] decide(bit p_ext, bit g, bit e);
    if (p_ext) return e ? 2'b10 : (g ? 2'b01 : 2'b00);
    return g ? 2'b01 : (e ? 2'b10 : 2'b00);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance model after inputs settle, then compare every output
  task automatic settle_and_check(string req, bit force_dec);
    bit trig;
    repeat (SETTLE) @(negedge clk);
    trig = force_dec || (sw != m_sw) || (ext_run != m_ext);
    if (trig) begin
      m_sw  = sw;
      m_ext = ext_run;
      m_pulses++;
      m_code = decide(sw, gps, ext_run);
      case (m_code)
        2'b01:   begin m_led = 3'b101; m_pps = 1'b1; end
        2'b10:   begin m_led = 3'b011; m_pps = 1'b0; end
        default: m_led = 3'b000;
      endcase
    end
    check({req, " pulses"}, pulses, m_pulses);
    check({req, " code"}, code, m_code);
    check({req, " led"}, led, m_led);
    check({req, " pps"}, pps, m_pps);
    if (trig) check({req, " R12 pulse code"}, last_code, m_code);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: power-up state before the first decision
    check("R11 led", led, 3'b110);
    check("R11 pps", pps, 1);
    check("R11 reconf", reconf, 0);
    // R10 forced first decision, R4/R6 internal preferred and present
    settle_and_check("R10 R4 R6", 1'b1);
    // R9/R2: internal presence drop alone is ignored
    gps = 1'b0;
    settle_and_check("R9 R2 gps only", 1'b0);
    // R5/R8: prefer external, nothing present -> none, pps held
    sw = 1'b1;
    settle_and_check("R5 R8 none", 1'b0);
    // R1/R7: external toggles -> present -> external
    ext_run = 1'b1;
    settle_and_check("R1 R7 ext", 1'b0);
    // R3: glitch shorter than debounce hold
    sw = 1'b0;
    repeat (DEB / 2) @(negedge clk);
    sw = 1'b1;
    settle_and_check("R3 glitch", 1'b0);
    // R4 fallback: prefer internal, internal absent
    sw = 1'b0;
    settle_and_check("R4 fallback", 1'b0);
    gps = 1'b1;
    settle_and_check("R9 gps return", 1'b0);
    // R1 absence: external stops
    ext_run = 1'b0;
    settle_and_check("R1 R4 ext lost", 1'b0);
    // random single-input changes
    for (int i = 0; i < 30; i++) begin
      int sel = $urandom_range(0, 2);
      bit v = 1'($urandom_range(0, 1));
      case (sel)
        0: sw = v;
        1: gps = v;
        default: ext_run = v;
      endcase
      settle_and_check("R4 R5 R9 random", 1'b0);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule